// File: doc/BRIEF.md
# Programmable periodic interrupt generator

This block turns a 32768 Hz timebase, delivered as a one-cycle enable strobe in the system clock domain, into a programmable periodic tick. A 4-bit rate code selects the period. Each tick raises a one-cycle flag-set strobe. It also raises a one-cycle interrupt request if the interrupt enable is on, and a one-cycle pulse on the square-wave output if the square-wave enable is on. The square-wave output is a pulse per tick, not a 50% duty waveform.

A free-running timebase counter starts at zero on reset and counts strobes. A tick falls on the strobe that takes this count to a multiple of the selected period. Tick positions therefore do not depend on when the block was enabled or when the code was changed. The tick machine has three states. ST_OFF means the divider is gated. ST_RUN means it is waiting for a boundary. ST_FIRE is the single output cycle.

The transitions are as follows. ST_OFF goes to ST_RUN when the divider may run. ST_RUN goes to ST_FIRE on a strobe at a boundary, and returns to ST_OFF when the gate closes. ST_FIRE goes to ST_RUN, or to ST_OFF if the gate closed. All logic uses one clock and an active-high synchronous reset.

Top module: `pit_gen`

## Requirements
- R1: Rate code 0 produces no tick at all, whatever the enables are.
- R2: Rate codes 1 and 2 give periods of 128 and 256 timebase strobes, the same as codes 8 and 9.
- R3: For codes 3 to 15 the period is 2^(code-1) timebase strobes. The period counts strobes, not clock cycles, so sparse strobes stretch it in clock time.
- R4: No tick occurs while both the interrupt enable and the square-wave enable are low. Closing the gate in the middle of a period suppresses the pending tick.
- R5: A tick is the strobe that brings the strobe count since reset to a multiple of the period. The outputs pulse in the clock cycle right after that strobe's edge.
- R6: Every tick raises `flag_set` for exactly one cycle. `irq_req` pulses with it only if `irq_en` was high at the tick strobe.
- R7: `sqw_pulse` is a one-cycle pulse with the tick when `sqw_en` was high at the tick strobe, and it stays low otherwise.
- R8: After a rate code change, the first tick lands on a boundary of the new period, with no extra pulse.
- R9: During and right after reset, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| tb_stb | input | 1 | One-cycle 32768 Hz timebase strobe |
| rate_code | input | 4 | Period select; 0 stops the tick |
| irq_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| flag_set | output | 1 | One-cycle strobe on every tick |
| irq_req | output | 1 | One-cycle interrupt request on a tick with `irq_en` |
| sqw_pulse | output | 1 | One-cycle pulse on a tick with `sqw_en` |

## Verification
The assertions assume that the rate code, the enables and the strobe change only between clock edges, and that reset is held for at least one edge before operation. They also rely on the decoded period being at least four strobes, so a tick can never follow the one-cycle output state directly. The stimulus drives every input on the falling edge. It produces strobes either every cycle or every third cycle, and changes the rate code only during the output cycle or in the middle of a period. The bench counts strobes since reset and checks each pulse against that count arithmetically, sweeping all fifteen nonzero codes.

// File: rtl/pit_pkg.sv
package pit_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } pit_state_e;
endpackage

// File: rtl/pit_timebase.sv
module pit_timebase #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tb_stb,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tb_stb) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: the count moves only on a strobe
    a_r5_count_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !tb_stb |=> $stable(cnt));
endmodule

// File: rtl/pit_rate_decode.sv
module pit_rate_decode #(
    parameter int CODE_W    = 4,
    parameter int CNT_W     = 15,
    parameter int LOW_REMAP = 2,
    parameter int REMAP_ADD = 7
) (
    input  logic [CODE_W-1:0] rate_code,
    output logic              active,
    output logic [CNT_W-1:0]  mask
);
    localparam int EFF_W = CODE_W + 1;

    logic [EFF_W-1:0] eff;

    always_comb begin
        active = (rate_code != '0);
        if (rate_code <= CODE_W'(LOW_REMAP)) begin
            eff = {1'b0, rate_code} + EFF_W'(REMAP_ADD);
        end else begin
            eff = {1'b0, rate_code};
        end
    end

    // mask holds (eff-1) low ones: period 2^(eff-1)
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = active && (eff > EFF_W'(i + 1));
    end
endmodule

// File: rtl/pit_tick_fsm.sv
module pit_tick_fsm
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tb_stb,
    input  logic hit,
    input  logic run_ok,
    input  logic irq_en,
    input  logic sqw_en,
    output logic flag_set,
    output logic irq_req,
    output logic sqw_pulse
);
    pit_state_e state, nxt;
    logic       irq_q, sqw_q;
    logic       fire_go;

    assign fire_go = run_ok && tb_stb && hit;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:  nxt = run_ok ? ST_RUN : ST_OFF;
            ST_RUN:  nxt = !run_ok ? ST_OFF : (fire_go ? ST_FIRE : ST_RUN);
            ST_FIRE: nxt = run_ok ? ST_RUN : ST_OFF;
            default: nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            sqw_q <= 1'b0;
        end else if (state == ST_RUN && fire_go) begin
            irq_q <= irq_en;
            sqw_q <= sqw_en;
        end
    end

    always_comb begin
        flag_set  = (state == ST_FIRE);
        irq_req   = (state == ST_FIRE) && irq_q;
        sqw_pulse = (state == ST_FIRE) && sqw_q;
    end

    a_r6_flag_one_cycle: assert property (@(posedge clk) disable iff (rst)
        flag_set |=> !flag_set);
    a_r6_irq_with_flag: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> flag_set);
    a_r6_irq_follows_enable: assert property (@(posedge clk) disable iff (rst)
        flag_set |-> (irq_req == $past(irq_en)));
    a_r7_sqw_with_flag: assert property (@(posedge clk) disable iff (rst)
        sqw_pulse |-> flag_set);
    a_r7_sqw_follows_enable: assert property (@(posedge clk) disable iff (rst)
        flag_set |-> (sqw_pulse == $past(sqw_en)));
endmodule

// File: rtl/pit_gen.sv
module pit_gen #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tb_stb,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              irq_en,
    input  logic              sqw_en,
    output logic              flag_set,
    output logic              irq_req,
    output logic              sqw_pulse
);
    localparam int CNT_W = (1 << CODE_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;
    logic             active;
    logic             hit;
    logic             run_ok;

    pit_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .tb_stb (tb_stb),
        .cnt    (cnt)
    );

    pit_rate_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W), .LOW_REMAP(2), .REMAP_ADD(7)) u_dec (
        .rate_code (rate_code),
        .active    (active),
        .mask      (mask)
    );

    assign hit    = ((cnt & mask) == mask);
    assign run_ok = active && (irq_en || sqw_en);

    pit_tick_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tb_stb    (tb_stb),
        .hit       (hit),
        .run_ok    (run_ok),
        .irq_en    (irq_en),
        .sqw_en    (sqw_en),
        .flag_set  (flag_set),
        .irq_req   (irq_req),
        .sqw_pulse (sqw_pulse)
    );

    a_r1_no_tick_code0: assert property (@(posedge clk) disable iff (rst)
        flag_set |-> ($past(rate_code) != '0));
    a_r4_gate_open: assert property (@(posedge clk) disable iff (rst)
        flag_set |-> $past(irq_en || sqw_en));
    a_r5_after_strobe: assert property (@(posedge clk) disable iff (rst)
        flag_set |-> $past(tb_stb));
    a_r5_aligned: assert property (@(posedge clk) disable iff (rst)
        flag_set |-> ((cnt & $past(mask)) == '0));
endmodule

// File: tb/test_pit_gen.sv
module test_pit_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stb;
    logic [3:0] code = 4'd0;
    logic       pie = 1'b0;
    logic       sqe = 1'b0;
    logic       pf, irq, sq;

    int    total = 0;
    int    bad = 0;
    int    nstb;
    int    stb_gap = 1;
    int    stb_ph;
    int    cur_p = 4;
    int    pulses = 0;
    logic  quiet = 1'b1;
    logic  exp_irq = 1'b0;
    logic  exp_sqw = 1'b0;
    string tag = "R1";
    int    last_n = 0;
    logic  have_last = 1'b0;
    logic  prev_pf = 1'b0;

    always #5 clk = ~clk;

    pit_gen i_pit_gen (
        .clk       (clk),
        .rst       (rst),
        .tb_stb    (stb),
        .rate_code (code),
        .irq_en    (pie),
        .sqw_en    (sqe),
        .flag_set  (pf),
        .irq_req   (irq),
        .sqw_pulse (sq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int per(input int c);
        int e;
        e = (c <= 2) ? c + 7 : c;
        return 1 << (e - 1);
    endfunction

    // strobes issued since reset
    always @(posedge clk) begin
        if (rst) nstb <= 0;
        else if (stb) nstb <= nstb + 1;
    end

    always @(negedge clk) begin
        if (rst) begin
            stb    <= 1'b0;
            stb_ph <= 0;
        end else begin
            stb    <= (stb_ph == 0);
            stb_ph <= (stb_ph + 1 >= stb_gap) ? 0 : stb_ph + 1;
        end
    end

    // output monitor, samples 3 ns after the rising edge
    always begin
        @(posedge clk);
        #3;
        if (!rst) begin
            if (pf && prev_pf) chk(1'b0, "R6", "flag wider than one cycle", 1, 0);
            if (pf) begin
                pulses++;
                if (quiet) begin
                    chk(1'b0, tag, "tick in quiet window", 1, 0);
                end else begin
                    chk((nstb % cur_p) == 0, "R5", "tick strobe count mod period", nstb % cur_p, 0);
                    if (have_last)
                        chk((nstb - last_n) == cur_p, tag, "tick interval in strobes", nstb - last_n, cur_p);
                    chk(irq == exp_irq, "R6", "irq_req at tick", int'(irq), int'(exp_irq));
                    chk(sq == exp_sqw, "R7", "sqw_pulse at tick", int'(sq), int'(exp_sqw));
                end
                last_n    = nstb;
                have_last = 1'b1;
            end else begin
                chk(!irq && !sq, "R6", "irq/sqw without flag", int'(irq) + int'(sq), 0);
            end
            prev_pf = pf;
        end
    end

    task automatic wait_pulses(input int n, input int lim, input string req);
        int target;
        int k;
        target = pulses + n;
        k = 0;
        while (pulses < target && k < lim) begin
            @(negedge clk);
            k++;
        end
        chk(pulses >= target, req, "ticks seen before timeout", pulses - (target - n), n);
    endtask

    task automatic setup(input int c, input logic ie, input logic se, input string t);
        code      = 4'(c);
        pie       = ie;
        sqe       = se;
        cur_p     = per(c);
        exp_irq   = ie;
        exp_sqw   = se;
        tag       = t;
        have_last = 1'b0;
    endtask

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        chk(!pf && !irq && !sq, "R9", "outputs in reset", int'(pf) + int'(irq) + int'(sq), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!pf && !irq && !sq, "R9", "outputs after reset", int'(pf) + int'(irq) + int'(sq), 0);

        // R1: code 0 with both enables on
        quiet = 1'b1;
        tag   = "R1";
        code  = 4'd0;
        pie   = 1'b1;
        sqe   = 1'b1;
        p0    = pulses;
        repeat (600) @(negedge clk);
        chk(pulses == p0, "R1", "ticks with code 0", pulses - p0, 0);

        // R4: gate closed
        tag  = "R4";
        code = 4'd3;
        pie  = 1'b0;
        sqe  = 1'b0;
        p0   = pulses;
        repeat (100) @(negedge clk);
        chk(pulses == p0, "R4", "ticks with enables off", pulses - p0, 0);

        // R2/R3: sweep all nonzero codes
        quiet = 1'b0;
        for (int c = 1; c <= 15; c++) begin
            setup(c, 1'b1, c[0], (c <= 2) ? "R2" : "R3");
            wait_pulses(2, 3 * per(c) + 20, (c <= 2) ? "R2" : "R3");
        end

        // R6: interrupt enable off, square wave on
        setup(5, 1'b0, 1'b1, "R6");
        wait_pulses(2, 3 * per(5) + 20, "R6");
        // R7: square wave off, interrupt on
        setup(5, 1'b1, 1'b0, "R7");
        wait_pulses(2, 3 * per(5) + 20, "R7");

        // R3: sparse strobes, one every third cycle
        stb_gap = 3;
        setup(4, 1'b1, 1'b1, "R3");
        wait_pulses(3, 3 * 3 * per(4) + 20, "R3");
        stb_gap = 1;

        // R8: rate changes in the middle of a period
        setup(6, 1'b1, 1'b1, "R8");
        wait_pulses(1, 3 * per(6) + 20, "R8");
        repeat (7) @(negedge clk);
        setup(3, 1'b1, 1'b1, "R8");
        wait_pulses(3, 3 * per(3) + 20, "R8");
        repeat (2) @(negedge clk);
        setup(7, 1'b1, 1'b1, "R8");
        wait_pulses(2, 3 * per(7) + 20, "R8");

        // R4: gate closed while running
        setup(3, 1'b1, 1'b1, "R4");
        wait_pulses(1, 3 * per(3) + 20, "R4");
        quiet = 1'b1;
        pie   = 1'b0;
        sqe   = 1'b0;
        p0    = pulses;
        repeat (50) @(negedge clk);
        chk(pulses == p0, "R4", "ticks after gate closed", pulses - p0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule